// File: doc/BRIEF.md
# Seeded Scrambled Test-Block Generator

This block produces a stream of 66-bit test blocks (2-bit sync header plus 64-bit payload) for the transmit side of a 10G 64b/66b PCS while it runs in pseudo-random test mode. The payload comes from a 58-bit self-synchronous scrambler, polynomial 1 + x^39 + x^58. The scrambler is fed either an all-zero data word or a fixed local-fault control word. Its state is not left to run freely: every 128 accepted blocks it is overwritten with the next seed in a fixed four-step rotation. The rotation is seed A, the bitwise inverse of seed A, seed B, then the bitwise inverse of seed B. A square-wave alternative skips the scrambler entirely.

Software supplies each seed as a 32-bit low word and a 26-bit high word, along with the data select, the square-wave select and the test enable. Downstream logic takes blocks through a valid/ready handshake. A block counts as accepted only in a cycle where valid and ready are both high.

Top module: `tpg_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `blk_valid` is 0.
- R2: `blk_valid` is the test enable delayed by one clock. It rises the cycle after `test_en` is first seen high and falls the cycle after `test_en` is seen low.
- R3: Each time the generator starts (`test_en` high while `blk_valid` is low), the first block uses seed A as the scrambler state and the 128-block count restarts from zero.
- R4: The payload is produced bit by bit from bit 0 upward as out = in ^ s39 ^ s58, where sK is the scrambler output K bits earlier. State carries over from one block to the next. The sync header is never scrambled.
- R5: After every 128th accepted block the scrambler state is reloaded from a seed instead of continuing.
- R6: Successive reloads follow the order A, ~A, B, ~B, then back to A. A seed is {high[25:0], low[31:0]}, where low word bit 0 is state bit 0 and state bit 0 is the most recent output bit.
- R7: With the zero select at 1, every block has header 2'b01 and the scrambler input is all zeros.
- R8: With the zero select at 0, every block has header 2'b10 and the scrambler input is 64'h0000_0000_0100_004B. That is a control-type byte 0x4B in bits 7:0 and 0x01 in bits 31:24.
- R9: With the square-wave select at 1, every block has header 2'b01 and payload 64'h0F0F_0F0F_0F0F_0F0F: four ones and four zeros repeating, starting from bit 0. The scrambler is bypassed.
- R10: While valid is high and ready is low, the presented block holds, and neither the count nor the scrambler state moves.
- R11: The zero select and square-wave select are captured at start. Changing them during a run has no effect on the output until the next start.
- R12: Each seed is read from the seed inputs in the cycle of its reload, so a seed changed before its turn takes effect at that turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_a_lo | input | 32 | Seed A bits 31:0 |
| seed_a_hi | input | 26 | Seed A bits 57:32 |
| seed_b_lo | input | 32 | Seed B bits 31:0 |
| seed_b_hi | input | 26 | Seed B bits 57:32 |
| zero_sel | input | 1 | 1: all-zero data input; 0: local-fault control input |
| sqw_sel | input | 1 | 1: square-wave blocks instead of scrambled ones |
| test_en | input | 1 | Test pattern generation enable |
| blk_ready | input | 1 | Downstream accepts the presented block |
| blk_valid | output | 1 | A block is presented |
| blk_hdr | output | 2 | Sync header of the presented block |
| blk_data | output | 64 | Payload of the presented block |

## Verification
The bench runs a bit-serial reference model against the design for several input patterns. A long zero-data run with ready held high walks through all four seed steps and wraps back to seed A, which exposes wrong rotation order, a wrong reload period or wrong tap positions. A local-fault run with random back-pressure separates the two data inputs and headers, and shows whether stalls disturb the count or the state. Seed B and the mode selects are changed mid-run to tell apart sampling at reload from sampling at start. A square-wave run and a one-cycle enable drop test the bypass path and the restart to seed A.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int SEED_W    = 58;
    localparam int LO_W      = 32;
    localparam int HI_W      = SEED_W - LO_W;
    localparam int BLK_W     = 64;
    localparam int TAP_NEAR  = 39;
    localparam int SQW_HALF  = 4;

    localparam logic [1:0] HDR_DATA = 2'b01;
    localparam logic [1:0] HDR_CTRL = 2'b10;

    localparam logic [7:0] LF_TYPE  = 8'h4B;
    localparam logic [7:0] LF_CODE  = 8'h01;

    typedef enum logic [1:0] {
        SEL_A     = 2'd0,
        SEL_A_INV = 2'd1,
        SEL_B     = 2'd2,
        SEL_B_INV = 2'd3
    } seed_sel_e;

    typedef struct packed {
        logic [1:0]       hdr;
        logic [BLK_W-1:0] data;
    } blk_t;

    typedef struct packed {
        logic [SEED_W-1:0] state;
        logic [BLK_W-1:0]  data;
    } scr_res_t;

    typedef struct packed {
        logic zero;
        logic sqw;
    } mode_t;

    // Bit-serial scramble of one payload, bit 0 first; s[0] is the newest output bit.
    function automatic scr_res_t scramble(input logic [SEED_W-1:0] st,
                                          input logic [BLK_W-1:0]  din);
        logic [SEED_W-1:0] s;
        logic              o;
        scr_res_t          r;
        r = '0;
        s = st;
        for (int i = 0; i < BLK_W; i++) begin
            o         = din[i] ^ s[TAP_NEAR-1] ^ s[SEED_W-1];
            r.data[i] = o;
            s         = {s[SEED_W-2:0], o};
        end
        r.state = s;
        return r;
    endfunction

    function automatic logic [BLK_W-1:0] lf_word();
        logic [BLK_W-1:0] w;
        w        = '0;
        w[7:0]   = LF_TYPE;
        w[31:24] = LF_CODE;
        return w;
    endfunction

    function automatic logic [SEED_W-1:0] seed_pick(input seed_sel_e        sel,
                                                    input logic [SEED_W-1:0] a,
                                                    input logic [SEED_W-1:0] b);
        logic [SEED_W-1:0] v;
        unique case (sel)
            SEL_A:     v = a;
            SEL_A_INV: v = ~a;
            SEL_B:     v = b;
            default:   v = ~b;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tpg_seed_seq.sv
module tpg_seed_seq
    import tpg_pkg::*;
#(
    parameter int EPOCH_BLKS = 128,
    localparam int CNT_W     = $clog2(EPOCH_BLKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fire,
    input  logic [SEED_W-1:0] seed_a,
    input  logic [SEED_W-1:0] seed_b,
    output logic              load,
    output logic [SEED_W-1:0] load_val
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(EPOCH_BLKS - 1);

    logic [CNT_W-1:0] cnt;
    seed_sel_e        step;
    seed_sel_e        step_nxt;
    logic             wrap;

    assign step_nxt = seed_sel_e'(step + 2'd1);
    assign wrap     = fire && (cnt == LAST);
    assign load     = start || wrap;
    assign load_val = seed_pick(start ? SEL_A : step_nxt, seed_a, seed_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            step <= SEL_A;
        end else if (start) begin
            cnt  <= '0;
            step <= SEL_A;
        end else if (wrap) begin
            cnt  <= '0;
            step <= step_nxt;
        end else if (fire) begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R5 R6
    epoch_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !start && cnt == LAST) |=> (cnt == '0 && step == seed_sel_e'($past(step) + 2'd1)));

    // R3
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == '0 && step == SEL_A));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !fire) |=> ($stable(cnt) && $stable(step)));

endmodule

// File: rtl/tpg_scrambler.sv
module tpg_scrambler
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SEED_W-1:0] load_val,
    input  logic              advance,
    input  logic [BLK_W-1:0]  din,
    output logic [BLK_W-1:0]  dout
);

    logic [SEED_W-1:0] state;
    scr_res_t          res;

    assign res  = scramble(state, din);
    assign dout = res.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (load) begin
            state <= load_val;
        end else if (advance) begin
            state <= res.state;
        end
    end

    // R10
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(state));

endmodule

// File: rtl/tpg_source.sv
module tpg_source
    import tpg_pkg::*;
(
    input  mode_t            mode,
    input  logic [BLK_W-1:0] scr_out,
    output logic [BLK_W-1:0] scr_in,
    output blk_t             blk
);

    logic [BLK_W-1:0] sqw_w;

    for (genvar g = 0; g < BLK_W; g++) begin : g_sqw
        assign sqw_w[g] = (((g / SQW_HALF) % 2) == 0);
    end

    assign scr_in = mode.zero ? '0 : lf_word();

    always_comb begin
        if (mode.sqw) begin
            blk.hdr  = HDR_DATA;
            blk.data = sqw_w;
        end else begin
            blk.hdr  = mode.zero ? HDR_DATA : HDR_CTRL;
            blk.data = scr_out;
        end
    end

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int EPOCH_BLKS = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LO_W-1:0] seed_a_lo,
    input  logic [HI_W-1:0] seed_a_hi,
    input  logic [LO_W-1:0] seed_b_lo,
    input  logic [HI_W-1:0] seed_b_hi,
    input  logic            zero_sel,
    input  logic            sqw_sel,
    input  logic            test_en,
    input  logic            blk_ready,
    output logic            blk_valid,
    output logic [1:0]      blk_hdr,
    output logic [BLK_W-1:0] blk_data
);

    logic              active;
    mode_t             mode_q;
    logic              start;
    logic              fire;
    logic              load;
    logic [SEED_W-1:0] load_val;
    logic [BLK_W-1:0]  scr_in;
    logic [BLK_W-1:0]  scr_out;
    blk_t              blk;

    assign start = test_en && !active;
    assign fire  = active && test_en && blk_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            mode_q <= '0;
        end else begin
            active <= test_en;
            if (start) begin
                mode_q.zero <= zero_sel;
                mode_q.sqw  <= sqw_sel;
            end
        end
    end

    tpg_seed_seq #(
        .EPOCH_BLKS (EPOCH_BLKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .fire     (fire),
        .seed_a   ({seed_a_hi, seed_a_lo}),
        .seed_b   ({seed_b_hi, seed_b_lo}),
        .load     (load),
        .load_val (load_val)
    );

    tpg_scrambler u_scr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .advance  (fire),
        .din      (scr_in),
        .dout     (scr_out)
    );

    tpg_source u_src (
        .mode    (mode_q),
        .scr_out (scr_out),
        .scr_in  (scr_in),
        .blk     (blk)
    );

    assign blk_valid = active;
    assign blk_hdr   = blk.hdr;
    assign blk_data  = blk.data;

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        test_en |=> blk_valid);

    // R2
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> !blk_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && !blk_ready && test_en) |=> ($stable(blk_data) && $stable(blk_hdr)));

    // R7 R8
    hdr_legal_chk: assert property (@(posedge clk) disable iff (rst)
        blk_valid |-> ($countones(blk_hdr) == 1));

    // R11
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && test_en) |=> $stable(mode_q));

endmodule

// File: tb/tpg_top_tb.sv
module tpg_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] seed_a_lo = '0;
    logic [25:0] seed_a_hi = '0;
    logic [31:0] seed_b_lo = '0;
    logic [25:0] seed_b_hi = '0;
    logic        zero_sel = 1'b1;
    logic        sqw_sel = 1'b0;
    logic        test_en = 1'b0;
    logic        blk_ready = 1'b1;
    logic        blk_valid;
    logic [1:0]  blk_hdr;
    logic [63:0] blk_data;

    always #4 clk = ~clk;

    tpg_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .seed_a_lo (seed_a_lo),
        .seed_a_hi (seed_a_hi),
        .seed_b_lo (seed_b_lo),
        .seed_b_hi (seed_b_hi),
        .zero_sel  (zero_sel),
        .sqw_sel   (sqw_sel),
        .test_en   (test_en),
        .blk_ready (blk_ready),
        .blk_valid (blk_valid),
        .blk_hdr   (blk_hdr),
        .blk_data  (blk_data)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag   = "R1";
    bit    done  = 0;

    // reference model state
    bit     m_active = 0;
    bit     m_zero = 0;
    bit     m_sqw = 0;
    int     m_cnt = 0;
    int     m_step = 0;
    bit     hist[$];

    localparam logic [63:0] LF_IN  = 64'h0000_0000_0100_004B;
    localparam logic [63:0] SQW_PL = 64'h0F0F_0F0F_0F0F_0F0F;

    function automatic logic [57:0] seed_of(int step);
        logic [57:0] a, b;
        a = {seed_a_hi, seed_a_lo};
        b = {seed_b_hi, seed_b_lo};
        case (step)
            0: return a;
            1: return ~a;
            2: return b;
            default: return ~b;
        endcase
    endfunction

    function automatic void load_hist(logic [57:0] s);
        hist.delete();
        for (int k = 57; k >= 0; k--) hist.push_back(s[k]);
    endfunction

    function automatic logic [63:0] run_bits(bit commit);
        bit          h[$];
        logic [63:0] d, o;
        h = hist;
        d = m_zero ? 64'h0 : LF_IN;
        for (int i = 0; i < 64; i++) begin
            bit b;
            b = d[i] ^ h[h.size()-39] ^ h[h.size()-58];
            o[i] = b;
            h.push_back(b);
            void'(h.pop_front());
        end
        if (commit) hist = h;
        return o;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0;
        end else if (!m_active && test_en) begin
            m_active = 1;
            m_cnt = 0;
            m_step = 0;
            m_zero = zero_sel;
            m_sqw = sqw_sel;
            load_hist(seed_of(0));
        end else if (m_active && !test_en) begin
            m_active = 0;
        end else if (m_active && blk_ready) begin
            void'(run_bits(1));
            m_cnt++;
            if (m_cnt == 128) begin
                m_cnt = 0;
                m_step = (m_step + 1) % 4;
                load_hist(seed_of(m_step));
            end
        end
    end

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(blk_valid == m_active, "valid", 64'(blk_valid), 64'(m_active));
            if (m_active && blk_valid) begin
                logic [1:0]  eh;
                logic [63:0] ed;
                eh = (m_sqw || m_zero) ? 2'b01 : 2'b10;
                ed = m_sqw ? SQW_PL : run_bits(0);
                chk(blk_hdr == eh, "hdr", 64'(blk_hdr), 64'(eh));
                chk(blk_data == ed, "data", blk_data, ed);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int wd;
        wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 200000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below 200000", wd);
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        cycles(4);
        rst = 1'b0;
        cycles(2);
        chk(blk_valid == 1'b0, "valid after reset", 64'(blk_valid), 64'd0);

        // R2 R3 R4 R5 R6 R7: zero data, ready held, walk full rotation and wrap
        seed_a_lo = 32'hDEAD_BEEF;
        seed_a_hi = 26'h2A5_5A5A;
        seed_b_lo = 32'h1234_5678;
        seed_b_hi = 26'h013_5791;
        zero_sel  = 1'b1;
        sqw_sel   = 1'b0;
        blk_ready = 1'b1;
        tag = "R2 R3 R4 R7";
        test_en = 1'b1;
        cycles(60);
        // R11: mode change mid-run ignored; R12: seed B changed before its turn
        tag = "R5 R6 R11 R12";
        zero_sel  = 1'b0;
        sqw_sel   = 1'b1;
        seed_b_lo = 32'hCAFE_F00D;
        seed_b_hi = 26'h3FF_0001;
        cycles(560);

        // R2: enable low drops valid
        tag = "R2";
        test_en = 1'b0;
        cycles(3);

        // R8 R10: local fault data with random back-pressure
        tag = "R8 R10 R3";
        zero_sel = 1'b0;
        sqw_sel  = 1'b0;
        test_en  = 1'b1;
        for (int i = 0; i < 700; i++) begin
            blk_ready = ($urandom_range(0, 2) != 0);
            cycles(1);
        end
        blk_ready = 1'b1;

        // R3: one-cycle enable drop restarts at seed A
        tag = "R3";
        test_en = 1'b0;
        cycles(1);
        test_en = 1'b1;
        zero_sel = 1'b1;
        cycles(150);

        // R9: square wave
        tag = "R9";
        test_en = 1'b0;
        cycles(2);
        sqw_sel = 1'b1;
        test_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            blk_ready = i[0];
            cycles(1);
        end
        test_en = 1'b0;
        cycles(3);

        finish_run();
    end

endmodule